// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two independent 16-bit count units, each made of a low byte and a high byte, configured together by one 8-bit mode register. Each unit either counts internal machine cycles (marked by a one-clock enable pulse) or counts falling transitions on its own external event pin. Each unit runs only while its run-control bit is set and, when its gate option is chosen, only while its external gate pin is high.

Four counting arrangements are offered per unit: a 13-bit counter (5 bits of the low byte under the full high byte), a full 16-bit counter, an 8-bit counter that reloads itself from the high byte, and a split arrangement in which unit 0 becomes two separate 8-bit counters. In that last arrangement the second 8-bit counter borrows unit 1's run bit and overflow flag. Software loads and reads the five registers through a byte-wide write port and a combinational read port. It watches two sticky overflow flags, which it clears with a dedicated clear input.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset all four count bytes, the mode register and both overflow flags read as zero.
- R2: A write takes effect on the next clock at these addresses: 88h mode register, 8Ah unit 0 low byte, 8Bh unit 1 low byte, 8Ch unit 0 high byte, 8Dh unit 1 high byte. Reads are combinational, and any other read address returns zero.
- R3: Mode register bits 7:4 configure unit 0 and bits 3:0 configure unit 1. Within each nibble, bit 3 is gate enable, bit 2 is event select (1 = external pin, 0 = machine cycles) and bits 1:0 are the arrangement (00 13-bit, 01 16-bit, 10 auto-reload, 11 split).
- R4: A unit advances only while its run bit is 1 and either its gate enable is 0 or its gate pin is 1; otherwise its count bytes hold.
- R5: With event select 0, a unit takes one step per machine-cycle enable. With event select 1, it takes one step on an enable at which the pin is low, provided the pin was high at the previous enable.
- R6: In arrangement 01 the high:low pair counts as 16 bits; the step from FFFFh to 0000h sets the unit's overflow flag.
- R7: In arrangement 00, low bits 4:0 and the high byte form a 13-bit count. Low bits 7:5 keep their value, and the wrap from all ones sets the overflow flag.
- R8: In arrangement 10 the low byte counts. On a step from FFh it loads the high byte's value and sets the overflow flag, and the high byte never changes by counting.
- R9: In arrangement 11 on unit 0, the low byte is an 8-bit counter under unit 0's controls and sets flag 0. The high byte steps on every machine-cycle enable while run bit 1 is set, and its wrap sets flag 1. Overflows of unit 1 then leave flag 1 alone, and unit 1 set to arrangement 11 holds its count.
- R10: An overflow flag stays set until its clear input is 1. An overflow in the same cycle as a clear leaves the flag set.
- R11: A write to a count byte in the same cycle as a step of that byte wins; the other byte of the unit still steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleEn | input | 1 | Machine-cycle enable pulse |
| extCnt | input | 2 | External event pins, bit i for unit i |
| gateIn | input | 2 | External gate pins, bit i for unit i |
| runCtl | input | 2 | Run-control bits, bit i for unit i |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 8 | Register read address |
| rdData | output | 8 | Register read data |
| ovfClr | input | 2 | Overflow flag clear, bit i for unit i |
| ovfFlag | output | 2 | Sticky overflow flags |

## Verification
The assertions take for granted that every input is synchronous to the clock and that the mode register changes only through the write port. A step decided in a cycle therefore always uses the arrangement already held, never one being written in the same cycle. The event-select check assumes the pin is sampled only at machine-cycle enables. The stimulus changes all inputs only at the falling clock edge and reaches the mode register only through writes. It includes gaps and irregular patterns in the machine-cycle enable, so the hold and stability properties are exercised with the enable both present and absent.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned N_UNITS = 2;

  typedef enum logic [1:0] {
    TM_PRESCALE13 = 2'b00,
    TM_FULL16     = 2'b01,
    TM_AUTOLOAD   = 2'b10,
    TM_SPLIT      = 2'b11
  } tmrMode_e;

  // One nibble of the mode register, MSB first: gate, event select, arrangement
  typedef struct packed {
    logic     gate;
    logic     evtSel;
    tmrMode_e mode;
  } tmrCfg_t;

  localparam int unsigned CFG_W  = $bits(tmrCfg_t);
  localparam int unsigned MODE_W = N_UNITS * CFG_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic [N_UNITS-1:0] step;
    logic               hiSplitStep;
    logic [N_UNITS-1:0] wrLo;
    logic [N_UNITS-1:0] wrHi;
    logic [N_UNITS-1:0] flagClr;
  } tmrStrobe_t;

  localparam logic [7:0] ADR_MODE = 8'h88;
  localparam logic [7:0] ADR_LO0  = 8'h8A;
  localparam logic [7:0] ADR_LO1  = 8'h8B;
  localparam logic [7:0] ADR_HI0  = 8'h8C;
  localparam logic [7:0] ADR_HI1  = 8'h8D;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cycleEn,
  input  logic [N_UNITS-1:0]       extCnt,
  input  logic [N_UNITS-1:0]       gateIn,
  input  logic [N_UNITS-1:0]       runCtl,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [N_UNITS-1:0]       ovfClr,
  output tmrMode_e [N_UNITS-1:0]   unitMode,
  output logic [MODE_W-1:0]        modeReg,
  output tmrStrobe_t               strobe
);

  tmrCfg_t [N_UNITS-1:0] cfg;
  logic [N_UNITS-1:0]    pinPrev;
  logic [N_UNITS-1:0]    evtTick;
  logic [N_UNITS-1:0]    allowed;
  logic [N_UNITS-1:0]    srcTick;
  logic                  wrModeHit;

  assign wrModeHit = wrEn && (wrAddr == ADDR_W'(ADR_MODE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
    end else if (wrModeHit) begin
      modeReg <= wrData[MODE_W-1:0];
    end
  end

  // pin history is taken only at machine-cycle enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev <= '0;
    end else if (cycleEn) begin
      pinPrev <= extCnt;
    end
  end

  assign evtTick = {N_UNITS{cycleEn}} & pinPrev & ~extCnt;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_cfg
    // unit 0 lives in the upper nibble
    assign cfg[i]      = modeReg[(N_UNITS-1-i)*CFG_W +: CFG_W];
    assign unitMode[i] = cfg[i].mode;
    assign allowed[i]  = runCtl[i] && (!cfg[i].gate || gateIn[i]);
    assign srcTick[i]  = cfg[i].evtSel ? evtTick[i] : cycleEn;
    assign strobe.step[i] = allowed[i] && srcTick[i];

    // R4: a closed gate blocks every step
    a_r4_gate_blocks: assert property (@(posedge clk) disable iff (!rstN)
      (cfg[i].gate && !gateIn[i]) |-> !strobe.step[i]);

    // R5: an event-counting step only on an enable with the pin low
    a_r5_event_low: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.step[i] && cfg[i].evtSel) |-> (cycleEn && !extCnt[i]));

    a_r5_step_on_enable: assert property (@(posedge clk) disable iff (!rstN)
      strobe.step[i] |-> cycleEn);
  end

  assign strobe.hiSplitStep = cycleEn && runCtl[1] && (cfg[0].mode == TM_SPLIT);

  assign strobe.wrLo[0] = wrEn && (wrAddr == ADDR_W'(ADR_LO0));
  assign strobe.wrLo[1] = wrEn && (wrAddr == ADDR_W'(ADR_LO1));
  assign strobe.wrHi[0] = wrEn && (wrAddr == ADDR_W'(ADR_HI0));
  assign strobe.wrHi[1] = wrEn && (wrAddr == ADDR_W'(ADR_HI1));
  assign strobe.flagClr = ovfClr;

  // R9: the borrowed high-byte counter runs only in split arrangement
  a_r9_split_only: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hiSplitStep |-> (unitMode[0] == TM_SPLIT && runCtl[1]));

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LO13_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tmrMode_e [N_UNITS-1:0] unitMode,
  input  logic [MODE_W-1:0]      modeReg,
  input  tmrStrobe_t             strobe,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [DATA_W-1:0]      rdData,
  output logic [N_UNITS-1:0]     ovfFlag
);

  localparam int unsigned J13_W = DATA_W + LO13_W;
  localparam int unsigned J16_W = 2 * DATA_W;
  localparam logic [J13_W-1:0]  ONE13 = J13_W'(1);
  localparam logic [J16_W-1:0]  ONE16 = J16_W'(1);
  localparam logic [DATA_W-1:0] ONE8  = DATA_W'(1);

  logic [N_UNITS-1:0][DATA_W-1:0] loCnt;
  logic [N_UNITS-1:0][DATA_W-1:0] hiCnt;
  logic [N_UNITS-1:0]             mainOvf;
  logic [N_UNITS-1:0]             hiOvf;
  logic [N_UNITS-1:0]             flagSet;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    localparam bit SPLIT_HOST = (i == 0);
    logic [DATA_W-1:0] loNext, hiNext, loInc, hiInc;
    logic [J13_W-1:0]  join13, sum13;
    logic [J16_W-1:0]  join16, sum16;
    logic              ovfMain, ovfHi;

    always_comb begin
      join13  = {hiCnt[i], loCnt[i][LO13_W-1:0]};
      sum13   = join13 + ONE13;
      join16  = {hiCnt[i], loCnt[i]};
      sum16   = join16 + ONE16;
      loInc   = loCnt[i] + ONE8;
      hiInc   = hiCnt[i] + ONE8;
      loNext  = loCnt[i];
      hiNext  = hiCnt[i];
      ovfMain = 1'b0;
      ovfHi   = 1'b0;
      unique case (unitMode[i])
        TM_PRESCALE13: begin
          if (strobe.step[i]) begin
            loNext  = {loCnt[i][DATA_W-1:LO13_W], sum13[LO13_W-1:0]};
            hiNext  = sum13[J13_W-1:LO13_W];
            ovfMain = &join13;
          end
        end
        TM_FULL16: begin
          if (strobe.step[i]) begin
            {hiNext, loNext} = sum16;
            ovfMain = &join16;
          end
        end
        TM_AUTOLOAD: begin
          if (strobe.step[i]) begin
            if (&loCnt[i]) begin
              loNext  = hiCnt[i];
              ovfMain = 1'b1;
            end else begin
              loNext = loInc;
            end
          end
        end
        TM_SPLIT: begin
          if (SPLIT_HOST) begin
            if (strobe.step[i]) begin
              loNext  = loInc;
              ovfMain = &loCnt[i];
            end
            if (strobe.hiSplitStep) begin
              hiNext = hiInc;
              ovfHi  = &hiCnt[i];
            end
          end
        end
        default: ;
      endcase
      // software write beats counting on the same byte
      if (strobe.wrLo[i]) loNext = wrData;
      if (strobe.wrHi[i]) hiNext = wrData;
    end

    assign mainOvf[i] = ovfMain;
    assign hiOvf[i]   = ovfHi;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loCnt[i] <= '0;
        hiCnt[i] <= '0;
      end else begin
        loCnt[i] <= loNext;
        hiCnt[i] <= hiNext;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ovfFlag[i] <= 1'b0;
      end else if (flagSet[i]) begin
        ovfFlag[i] <= 1'b1;
      end else if (strobe.flagClr[i]) begin
        ovfFlag[i] <= 1'b0;
      end
    end

    // R4: low byte holds without a step or a write
    a_r4_lo_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.step[i] && !strobe.wrLo[i]) |=> $stable(loCnt[i]));

    // R8: auto-reload never changes the high byte by itself
    a_r8_hi_kept: assert property (@(posedge clk) disable iff (!rstN)
      (unitMode[i] == TM_AUTOLOAD && !strobe.wrHi[i]) |=> $stable(hiCnt[i]));

    // R7: unused low bits survive 13-bit counting
    a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
      (unitMode[i] == TM_PRESCALE13 && !strobe.wrLo[i])
        |=> $stable(loCnt[i][DATA_W-1:LO13_W]));

    // R10: a set flag stays set until cleared
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (ovfFlag[i] && !strobe.flagClr[i]) |=> ovfFlag[i]);
  end

  assign flagSet[0] = mainOvf[0];
  assign flagSet[1] = (mainOvf[1] && (unitMode[0] != TM_SPLIT)) || (|hiOvf);

  always_comb begin
    unique case (rdAddr)
      ADDR_W'(ADR_MODE): rdData = DATA_W'(modeReg);
      ADDR_W'(ADR_LO0):  rdData = loCnt[0];
      ADDR_W'(ADR_LO1):  rdData = loCnt[1];
      ADDR_W'(ADR_HI0):  rdData = hiCnt[0];
      ADDR_W'(ADR_HI1):  rdData = hiCnt[1];
      default:           rdData = '0;
    endcase
  end

  // R9: unit 1 in split arrangement is frozen
  a_r9_unit1_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (unitMode[1] == TM_SPLIT && !strobe.wrLo[1] && !strobe.wrHi[1])
      |=> $stable({hiCnt[1], loCnt[1]}));

endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LO13_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycleEn,
  input  logic [N_UNITS-1:0] extCnt,
  input  logic [N_UNITS-1:0] gateIn,
  input  logic [N_UNITS-1:0] runCtl,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic [N_UNITS-1:0] ovfClr,
  output logic [N_UNITS-1:0] ovfFlag
);

  tmrMode_e [N_UNITS-1:0] unitMode;
  logic [MODE_W-1:0]      modeReg;
  tmrStrobe_t             strobe;

  tmr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cycleEn  (cycleEn),
    .extCnt   (extCnt),
    .gateIn   (gateIn),
    .runCtl   (runCtl),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .ovfClr   (ovfClr),
    .unitMode (unitMode),
    .modeReg  (modeReg),
    .strobe   (strobe)
  );

  tmr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO13_W(LO13_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .unitMode (unitMode),
    .modeReg  (modeReg),
    .strobe   (strobe),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .ovfFlag  (ovfFlag)
  );

endmodule

// File: tb/tb_dual_timer_unit.sv
`timescale 1ns/1ps
module tb_dual_timer_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycleEn = 1'b0;
  logic [1:0] extCnt = 2'b00;
  logic [1:0] gateIn = 2'b00;
  logic [1:0] runCtl = 2'b00;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdAddr = 8'h88;
  logic [7:0] rdData;
  logic [1:0] ovfClr = 2'b00;
  logic [1:0] ovfFlag;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  dual_timer_unit dut (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .extCnt(extCnt),
    .gateIn(gateIn), .runCtl(runCtl), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .ovfClr(ovfClr), .ovfFlag(ovfFlag)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  int mTl[2] = '{0, 0};
  int mTh[2] = '{0, 0};
  int mMode = 0;
  int mFlag[2] = '{0, 0};
  int mPrev[2] = '{0, 0};

  always @(posedge clk or negedge rstN) begin : refModel
    int nib, gt, ev, md, n, evt, src;
    int stp[2];
    int setMain[2];
    int setHi, splitHi, split0;
    int nTl[2];
    int nTh[2];
    if (!rstN) begin
      mTl = '{0, 0}; mTh = '{0, 0}; mMode = 0; mFlag = '{0, 0}; mPrev = '{0, 0};
    end else begin
      for (int i = 0; i < 2; i++) begin
        nib = (i == 0) ? (mMode >> 4) & 15 : mMode & 15;
        gt = (nib >> 3) & 1; ev = (nib >> 2) & 1;
        evt = (cycleEn && mPrev[i] == 1 && !extCnt[i]) ? 1 : 0;
        src = ev ? evt : int'(cycleEn);
        stp[i] = (runCtl[i] && (gt == 0 || gateIn[i]) && src != 0) ? 1 : 0;
      end
      split0 = (((mMode >> 4) & 3) == 3) ? 1 : 0;
      splitHi = (cycleEn && runCtl[1] && split0 != 0) ? 1 : 0;
      setHi = 0;
      for (int i = 0; i < 2; i++) begin
        md = (i == 0) ? (mMode >> 4) & 3 : mMode & 3;
        nTl[i] = mTl[i]; nTh[i] = mTh[i]; setMain[i] = 0;
        if (md == 0 && stp[i] != 0) begin
          n = mTh[i] * 32 + (mTl[i] & 31);
          if (n == 8191) setMain[i] = 1;
          n = (n + 1) % 8192;
          nTl[i] = (mTl[i] & 224) | (n & 31);
          nTh[i] = n / 32;
        end else if (md == 1 && stp[i] != 0) begin
          n = mTh[i] * 256 + mTl[i];
          if (n == 65535) setMain[i] = 1;
          n = (n + 1) % 65536;
          nTl[i] = n % 256; nTh[i] = n / 256;
        end else if (md == 2 && stp[i] != 0) begin
          if (mTl[i] == 255) begin nTl[i] = mTh[i]; setMain[i] = 1; end
          else nTl[i] = mTl[i] + 1;
        end else if (md == 3 && i == 0) begin
          if (stp[0] != 0) begin
            if (mTl[0] == 255) setMain[0] = 1;
            nTl[0] = (mTl[0] + 1) % 256;
          end
          if (splitHi != 0) begin
            if (mTh[0] == 255) setHi = 1;
            nTh[0] = (mTh[0] + 1) % 256;
          end
        end
      end
      if (wrEn && wrAddr == 8'h8A) nTl[0] = wrData;
      if (wrEn && wrAddr == 8'h8B) nTl[1] = wrData;
      if (wrEn && wrAddr == 8'h8C) nTh[0] = wrData;
      if (wrEn && wrAddr == 8'h8D) nTh[1] = wrData;
      if (setMain[0] != 0) mFlag[0] = 1; else if (ovfClr[0]) mFlag[0] = 0;
      if ((setMain[1] != 0 && split0 == 0) || setHi != 0) mFlag[1] = 1;
      else if (ovfClr[1]) mFlag[1] = 0;
      mTl = nTl; mTh = nTh;
      if (cycleEn) begin mPrev[0] = int'(extCnt[0]); mPrev[1] = int'(extCnt[1]); end
      if (wrEn && wrAddr == 8'h88) mMode = wrData;
    end
  end

  function automatic int rdModel(logic [7:0] a);
    case (a)
      8'h88: return mMode;
      8'h8A: return mTl[0];
      8'h8B: return mTl[1];
      8'h8C: return mTh[0];
      8'h8D: return mTh[1];
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison, rotating through every address plus one unmapped
  logic [7:0] rdSeq[6] = '{8'h88, 8'h8A, 8'h8B, 8'h8C, 8'h8D, 8'h89};
  int rdIdx = 0;
  always @(negedge clk) begin
    chk(curReq, "ovfFlag0", int'(ovfFlag[0]), mFlag[0]);
    chk(curReq, "ovfFlag1", int'(ovfFlag[1]), mFlag[1]);
    chk(curReq, $sformatf("rdData@%0h", rdAddr), int'(rdData), rdModel(rdAddr));
    rdIdx = (rdIdx + 1) % 6;
    rdAddr = rdSeq[rdIdx];
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    // R1: reset values seen through the rotation
    curReq = "R1";
    idle(7);
    rstN = 1'b1;
    idle(6);

    // R2: register map write/read, unmapped address reads zero
    curReq = "R2";
    wr(8'h8A, 8'h11); wr(8'h8B, 8'h22); wr(8'h8C, 8'h33); wr(8'h8D, 8'h44);
    wr(8'h88, 8'h5A);
    idle(6);

    // R6 and R3: both nibbles select 16-bit, unit 0 overflows
    curReq = "R6";
    wr(8'h88, 8'h11);
    wr(8'h8A, 8'hFD); wr(8'h8C, 8'hFF);
    cycleEn = 1'b1; runCtl = 2'b01;
    idle(6);
    for (int k = 0; k < 10; k++) begin cycleEn = k[0]; idle(1); end
    cycleEn = 1'b1;

    // R10: clear flag 0
    curReq = "R10";
    ovfClr = 2'b01; idle(1); ovfClr = 2'b00; idle(2);

    // R4: gate on unit 0, pin low then high, then run bit off
    curReq = "R4";
    wr(8'h88, 8'h91);
    gateIn = 2'b00; idle(5);
    gateIn = 2'b01; idle(5);
    runCtl = 2'b00; idle(5);

    // R5: unit 1 counts pin falls, with enable gaps
    curReq = "R5";
    wr(8'h88, 8'h15);
    runCtl = 2'b10;
    for (int k = 0; k < 24; k++) begin
      extCnt[1] = (k % 4) < 2;
      cycleEn = (k % 7) != 3;
      idle(1);
    end
    cycleEn = 1'b1; extCnt = 2'b00;

    // R7: unit 1 13-bit, low bits 7:5 kept, wrap sets flag 1
    curReq = "R7";
    wr(8'h88, 8'h10);
    wr(8'h8B, 8'hFE); wr(8'h8D, 8'hFF);
    runCtl = 2'b10; idle(8);
    ovfClr = 2'b10; idle(1); ovfClr = 2'b00;

    // R8: unit 0 auto-reload from F0h
    curReq = "R8";
    runCtl = 2'b00;
    wr(8'h88, 8'h21);
    wr(8'h8C, 8'hF0); wr(8'h8A, 8'hFC);
    runCtl = 2'b01; idle(40);

    // R9: split arrangement, unit 1 overflow must not set flag 1
    curReq = "R9";
    runCtl = 2'b00; ovfClr = 2'b11; idle(1); ovfClr = 2'b00;
    wr(8'h88, 8'h31);
    wr(8'h8A, 8'hF0); wr(8'h8C, 8'hF8); wr(8'h8B, 8'hFE); wr(8'h8D, 8'hFF);
    runCtl = 2'b11; idle(30);
    wr(8'h88, 8'h33); idle(10);

    // R10: overflow in the same cycle as a held clear
    curReq = "R10";
    runCtl = 2'b00;
    wr(8'h88, 8'h11);
    wr(8'h8A, 8'hFE); wr(8'h8C, 8'hFF);
    ovfClr = 2'b01; runCtl = 2'b01; idle(4);
    ovfClr = 2'b00; idle(2);

    // R11: writes while counting
    curReq = "R11";
    wr(8'h8A, 8'h40); idle(2);
    wr(8'h8C, 8'h12); idle(2);
    wr(8'h8A, 8'hFF); idle(3);

    // R3: random mixes across all arrangements and both nibbles
    curReq = "R3";
    for (int k = 0; k < 3000; k++) begin
      cycleEn = ($urandom % 4) != 0;
      extCnt = 2'($urandom);
      gateIn = 2'($urandom);
      runCtl = (($urandom % 8) == 0) ? 2'($urandom) : runCtl | 2'($urandom);
      ovfClr = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      if (($urandom % 50) == 0) begin
        wrEn = 1'b1; wrAddr = 8'h88; wrData = 8'($urandom);
      end else if (($urandom % 40) == 0) begin
        wrEn = 1'b1; wrAddr = 8'h8A + 8'($urandom % 4); wrData = 8'($urandom);
      end else begin
        wrEn = 1'b0;
      end
      idle(1);
    end
    wrEn = 1'b0; ovfClr = 2'b00;
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule